// File: doc/BRIEF.md
# Double-Buffered Down-Counting PWM Channel

This block is a single pulse-width channel built around a down-counter. Software writes a period value and a threshold value into two staging registers. Neither value reaches the counter directly. The running pair of active registers takes a new copy only at two moments: while the refresh bit of the control group is held, or when the counter wraps through zero with reload enabled. Because of this, a new period and duty can be staged at any time, and they never cut into a period that is already under way.

The counter advances only on a tick strobe that an external prescaler supplies. The channel is driven by a four-bit control group, which is this channel's slice of a shared control word. The group has a start bit, a refresh bit, an inversion bit and a reload bit. The block has one variant for the final channel of a timer bank. In that variant, bit 2 of the group is the reload flag and the channel has no inversion. A threshold of all ones holds the output in its asserted state for the whole period.

Top module: `pwm_dbuf_channel`

## Requirements
- R1: After reset the channel is stopped, both staging registers and both active registers hold zero, and with the control group at zero the pin is high.
- R2: A write with `bufWrEn` high stores `bufWrData` into the period staging register when `bufWrSel` is 0, and into the threshold staging register when `bufWrSel` is 1. A staged value has no effect on the running count or threshold until the next copy.
- R3: While group bit 1 (refresh) is high, every clock edge copies both staging registers into the active registers, holds the channel stopped and ignores ticks.
- R4: With bit 0 (start) high and refresh low, a stopped channel enters the run state at the next edge. It then decrements the active count by one on each edge where `tick` is high, so one period spans (period value + 1) ticks.
- R5: When a tick arrives at count zero and reload is enabled (group bit 3, or bit 2 in the final-channel variant), both active registers are reloaded from staging and the next period starts.
- R6: When a tick arrives at count zero with reload disabled, the channel halts with its output inactive. It stays halted until start is cleared or refresh is raised.
- R7: While running, the channel is asserted whenever the active count is less than or equal to the active threshold. A threshold of all ones therefore gives 100 % assertion, and a threshold of zero gives exactly one tick per period.
- R8: The pin equals the asserted flag when group bit 2 (invert) is 1 and its complement when it is 0. A stopped channel therefore drives the inverse of the invert bit.
- R9: Clearing start while running stops the channel at the next edge, and the pin returns to its inactive level.
- R10: With parameter `LAST_GROUP` set, group bit 2 is the reload flag, group bit 3 has no effect, and the pin always uses the non-inverted mapping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick | input | 1 | Count-enable strobe from the prescaler |
| ctrlGroup | input | 4 | Control group: [0] start, [1] refresh, [2] invert (reload in final-channel variant), [3] reload |
| bufWrEn | input | 1 | Staging register write strobe |
| bufWrSel | input | 1 | Write target: 0 period, 1 threshold |
| bufWrData | input | CNT_W | Staging write data |
| pwmOut | output | 1 | PWM pin level |

## Verification
A corrupted active count shows up as a wrong number of asserted cycles inside a measured window of two periods. That error is visible no later than the first wrap through zero. If a staged value leaks into the running pair early, the duty of the current period changes at once. The bench catches this by changing the threshold in the middle of a period and counting asserted samples before and after the reload. A wrong run-state transition shows at the pin within one clock: the pin either fails to fall to its inactive level after a stop or a halt, or keeps toggling when it should not.

// File: rtl/pwm_dbuf_pkg.sv
`timescale 1ns/1ps
package pwm_dbuf_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_DONE = 2'd2
  } chanState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic load;   // copy staging into active registers
    logic dec;    // decrement active count
  } dpStrobe_t;
endpackage

// File: rtl/pwm_dbuf_ctrl.sv
`timescale 1ns/1ps
module pwm_dbuf_ctrl
  import pwm_dbuf_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      tick,
  input  logic      startReq,
  input  logic      refreshReq,
  input  logic      reloadReq,
  input  logic      cntZero,
  output dpStrobe_t strb,
  output logic      running
);
  chanState_t state, stateNxt;

  always_comb begin
    stateNxt = state;
    strb     = '0;
    if (refreshReq) begin
      strb.load = 1'b1;
      stateNxt  = ST_IDLE;
    end else begin
      unique case (state)
        ST_IDLE: if (startReq) stateNxt = ST_RUN;
        ST_RUN: begin
          if (!startReq) begin
            stateNxt = ST_IDLE;
          end else if (tick) begin
            if (cntZero) begin
              if (reloadReq) strb.load = 1'b1;
              else           stateNxt  = ST_DONE;
            end else begin
              strb.dec = 1'b1;
            end
          end
        end
        ST_DONE: if (!startReq) stateNxt = ST_IDLE;
        default: stateNxt = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= stateNxt;
  end

  assign running = (state == ST_RUN);

  // R3: refresh keeps the channel out of the run state
  a_r3_refresh_halts: assert property (@(posedge clk) disable iff (!rst_n)
    refreshReq |=> !running);

  // R9: start low means not running on the next cycle
  a_r9_stop_on_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (!startReq && !refreshReq) |=> !running);

  // R6: zero without reload leaves the run state
  a_r6_halt_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (running && startReq && !refreshReq && tick && cntZero && !reloadReq)
      |=> (state == ST_DONE));

  // R4: a halted channel never resumes while start stays high
  a_r4_no_self_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_DONE && startReq && !refreshReq) |=> (state == ST_DONE));
endmodule

// File: rtl/pwm_dbuf_dp.sv
`timescale 1ns/1ps
module pwm_dbuf_dp
  import pwm_dbuf_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  dpStrobe_t        strb,
  input  logic             running,
  input  logic             wrEn,
  input  logic             wrSel,
  input  logic [CNT_W-1:0] wrData,
  output logic             cntZero,
  output logic             activeLvl
);
  localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);
  localparam logic [CNT_W-1:0] FULL = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cntBufQ, cmpBufQ;
  logic [CNT_W-1:0] cntAct, cmpAct;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cntBufQ <= '0;
      cmpBufQ <= '0;
    end else if (wrEn) begin
      if (wrSel) cmpBufQ <= wrData;
      else       cntBufQ <= wrData;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cntAct <= '0;
      cmpAct <= '0;
    end else if (strb.load) begin
      cntAct <= cntBufQ;
      cmpAct <= cmpBufQ;
    end else if (strb.dec) begin
      cntAct <= cntAct - ONE;
    end
  end

  assign cntZero   = (cntAct == '0);
  assign activeLvl = running && (cntAct <= cmpAct);

  // R5: a copy takes the staged values
  a_r5_copy_from_stage: assert property (@(posedge clk) disable iff (!rst_n)
    strb.load |=> (cntAct == $past(cntBufQ) && cmpAct == $past(cmpBufQ)));

  // R4: one step down per decrement strobe
  a_r4_step_down: assert property (@(posedge clk) disable iff (!rst_n)
    strb.dec |=> (cntAct == $past(cntAct) - ONE));

  // R2: staging writes alone leave the active pair untouched
  a_r2_active_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (!strb.load && !strb.dec) |=> ($stable(cntAct) && $stable(cmpAct)));

  // R7: all-ones threshold asserts for the whole run
  a_r7_full_duty: assert property (@(posedge clk) disable iff (!rst_n)
    (running && cmpAct == FULL) |-> activeLvl);
endmodule

// File: rtl/pwm_dbuf_channel.sv
`timescale 1ns/1ps
module pwm_dbuf_channel
  import pwm_dbuf_pkg::*;
#(
  parameter int CNT_W      = 16,
  parameter bit LAST_GROUP = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic [3:0]       ctrlGroup,
  input  logic             bufWrEn,
  input  logic             bufWrSel,
  input  logic [CNT_W-1:0] bufWrData,
  output logic             pwmOut
);
  dpStrobe_t strb;
  logic running, cntZero, activeLvl;
  logic reloadReq, invEff;

  generate
    if (LAST_GROUP) begin : g_last
      logic unusedHighBit;
      assign reloadReq     = ctrlGroup[2];
      assign invEff        = 1'b0;
      assign unusedHighBit = ctrlGroup[3];
    end else begin : g_std
      assign reloadReq = ctrlGroup[3];
      assign invEff    = ctrlGroup[2];
    end
  endgenerate

  pwm_dbuf_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick),
    .startReq  (ctrlGroup[0]),
    .refreshReq(ctrlGroup[1]),
    .reloadReq (reloadReq),
    .cntZero   (cntZero),
    .strb      (strb),
    .running   (running)
  );

  pwm_dbuf_dp #(.CNT_W(CNT_W)) u_dp (
    .clk      (clk),
    .rst_n    (rst_n),
    .strb     (strb),
    .running  (running),
    .wrEn     (bufWrEn),
    .wrSel    (bufWrSel),
    .wrData   (bufWrData),
    .cntZero  (cntZero),
    .activeLvl(activeLvl)
  );

  assign pwmOut = invEff ? activeLvl : ~activeLvl;

  // R8: a stopped channel drives the inactive level
  a_r8_idle_level: assert property (@(posedge clk) disable iff (!rst_n)
    !running |-> (pwmOut == ~invEff));
endmodule

// File: tb/pwm_dbuf_channel_bench.sv
`timescale 1ns/1ps
module pwm_dbuf_channel_bench;
  localparam int W = 16;
  localparam int TIMEOUT_CYC = 200000;

  typedef struct packed {
    logic [15:0] cnt;
    logic [15:0] cmp;
    logic        inv;
    logic        slow;
    logic [7:0]  expHi;
  } vec_t;

  // R4/R7/R8 vectors: period, threshold, invert, half-rate tick, expected high samples over two periods
  localparam vec_t VECS [7] = '{
    '{16'd9, 16'd3,      1'b1, 1'b0, 8'd8},
    '{16'd9, 16'd3,      1'b0, 1'b0, 8'd12},
    '{16'd4, 16'hFFFF,   1'b1, 1'b0, 8'd10},
    '{16'd5, 16'd0,      1'b1, 1'b0, 8'd2},
    '{16'd7, 16'd7,      1'b1, 1'b0, 8'd16},
    '{16'd1, 16'd0,      1'b0, 1'b0, 8'd2},
    '{16'd3, 16'd1,      1'b1, 1'b1, 8'd8}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b0;
  logic [3:0] grp = 4'b0;
  logic [3:0] grpL = 4'b0;
  logic wrEn = 1'b0;
  logic wrSel = 1'b0;
  logic [W-1:0] wrData = '0;
  logic pwm, pwmL;
  int nChecks = 0;
  int nErrors = 0;

  always #2 clk = ~clk;

  pwm_dbuf_channel #(.CNT_W(W), .LAST_GROUP(1'b0)) u_pwm_dbuf_channel (
    .clk(clk), .rst_n(rst_n), .tick(tick), .ctrlGroup(grp),
    .bufWrEn(wrEn), .bufWrSel(wrSel), .bufWrData(wrData), .pwmOut(pwm));

  pwm_dbuf_channel #(.CNT_W(W), .LAST_GROUP(1'b1)) u_pwm_dbuf_channel_last (
    .clk(clk), .rst_n(rst_n), .tick(tick), .ctrlGroup(grpL),
    .bufWrEn(wrEn), .bufWrSel(wrSel), .bufWrData(wrData), .pwmOut(pwmL));

  task automatic check(input string req, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nErrors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic writeBuf(input logic sel, input logic [W-1:0] val);
    @(negedge clk);
    wrEn = 1'b1; wrSel = sel; wrData = val;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  // stage, refresh, then start with reload; grp = {reload, invert, refresh, start}
  task automatic armMain(input logic [W-1:0] c, input logic [W-1:0] p, input logic inv);
    writeBuf(1'b0, c);
    writeBuf(1'b1, p);
    @(negedge clk) grp = {1'b0, inv, 1'b1, 1'b0};
    @(negedge clk) grp = {1'b1, inv, 1'b0, 1'b1}; tick = 1'b1;
  endtask

  task automatic runLast(input logic [3:0] runGrp, output int lows);
    lows = 0;
    writeBuf(1'b0, 16'd2);
    writeBuf(1'b1, 16'd0);
    @(negedge clk) grpL = 4'b0010;
    @(negedge clk) grpL = runGrp; tick = 1'b1;
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      lows += (pwmL == 1'b0) ? 1 : 0;
    end
    grpL = 4'b0000;
  endtask

  initial begin
    #(TIMEOUT_CYC * 4);
    nErrors++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("Simulation finished: %0d checks, %0d errors", nChecks, nErrors);
    $finish;
  end

  initial begin
    int hi, hi2, lows;
    repeat (3) @(negedge clk);
    check("R1 pin during reset", pwm, 1);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 pin after reset", pwm, 1);
    grp = 4'b0100;
    @(negedge clk);
    check("R8 stopped pin with invert", pwm, 0);
    grp = 4'b0000;

    // table walk: R4 R7 R8
    foreach (VECS[i]) begin
      int win;
      armMain(VECS[i].cnt, VECS[i].cmp, VECS[i].inv);
      win = 2 * (int'(VECS[i].cnt) + 1) * (VECS[i].slow ? 2 : 1);
      hi = 0;
      for (int k = 0; k < win; k++) begin
        @(negedge clk);
        hi += pwm;
        if (VECS[i].slow) tick = (k % 2 == 1);
      end
      check($sformatf("R4 R7 R8 vector %0d high samples", i), hi, int'(VECS[i].expHi));
      grp = {1'b0, VECS[i].inv, 1'b0, 1'b0};
      tick = 1'b1;
      @(negedge clk);
    end

    // R2/R5: threshold staged mid-period waits for the reload
    armMain(16'd9, 16'd9, 1'b1);
    hi = 0;
    for (int k = 0; k < 10; k++) begin
      @(negedge clk);
      hi += pwm;
      if (k == 0) begin wrEn = 1'b1; wrSel = 1'b1; wrData = 16'd0; end
      if (k == 1) wrEn = 1'b0;
    end
    hi2 = 0;
    for (int k = 0; k < 10; k++) begin
      @(negedge clk);
      hi2 += pwm;
    end
    check("R2 staged threshold not used mid-period", hi, 10);
    check("R5 reload picks up staged threshold", hi2, 1);
    grp = 4'b0100;
    @(negedge clk);

    // R6: reload dropped mid-period, period completes then halts
    armMain(16'd3, 16'd3, 1'b1);
    hi = 0;
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      hi += pwm;
      if (k == 0) grp = 4'b0101;
    end
    check("R6 period completes after reload cleared", hi, 4);
    check("R6 halted pin inactive with start high", pwm, 0);
    grp = 4'b0100;
    @(negedge clk);

    // R9: clearing start stops at next edge
    armMain(16'd9, 16'hFFFF, 1'b1);
    repeat (3) @(negedge clk);
    check("R7 full threshold asserted while running", pwm, 1);
    grp = 4'b1100;
    @(negedge clk);
    check("R9 stop on start clear", pwm, 0);
    grp = 4'b0000;

    // R3: holding refresh keeps the channel stopped despite start and ticks
    writeBuf(1'b0, 16'd5);
    writeBuf(1'b1, 16'hFFFF);
    @(negedge clk) grp = 4'b1111; tick = 1'b1;
    hi = 0;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      hi += pwm;
    end
    check("R3 refresh holds channel stopped", hi, 0);
    grp = 4'b0000;

    // R10: final-channel variant
    @(negedge clk) grpL = 4'b0100;
    @(negedge clk);
    check("R10 no inversion in final channel", pwmL, 1);
    runLast(4'b0101, lows);
    check("R10 bit2 reloads in final channel", lows, 2);
    runLast(4'b0001, lows);
    check("R10 no reload halts after one period", lows, 1);
    runLast(4'b1001, lows);
    check("R10 bit3 ignored in final channel", lows, 1);

    $display("Simulation finished: %0d checks, %0d errors", nChecks, nErrors);
    $finish;
  end
endmodule